// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two bus strobes of a multiplexed external memory bus: the active-high address-latch strobe (`ale`) and the active-low program-store read strobe (`psen_n`). It runs at oscillator rate. One machine cycle is twelve clocks, made of six states of two clocks each. The current state number is exported so that neighbouring bus logic can align its own address and data timing to the strobes.

In the normal case the address-latch strobe fires twice per machine cycle, once in state 0 and once in state 3. When code is fetched from outside the device, the read strobe is asserted in two windows per cycle. A machine cycle that the core flags as an external data access or code-table read drops the state-0 latch pulse and both read windows. The core samples that flag once per cycle. A software bit can silence the latch strobe except in such flagged cycles. The bit has no effect while execution is external. Idle mode parks both strobes high. Power-down parks both strobes low and freezes the timebase.

The reset input is asynchronous and active low. Its release is synchronised, so the block starts counting on the third rising clock edge after `rst_n` goes high.

Top module: `msc_bus_strobes`

## Requirements
- R1: While reset is in effect (`rst_n` low, and for two clock edges after it rises) `ale` is 0, `psen_n` is 1 and `state_idx` is 0.
- R2: Outside power-down, `state_idx` advances by one every two clocks through the values 0 to 5 and wraps from 5 to 0, so one machine cycle is 12 clocks. The first active edge after reset enters the second clock of state 0.
- R3: In an unflagged running cycle with the ALE-disable bit clear, `ale` is 1 for exactly one clock: the second clock of state 0 and the second clock of state 3. It is 0 in every other clock.
- R4: `xdata_cyc` is sampled only at the clock edge that ends state 5, and it marks the whole machine cycle that begins there. Its value at any other edge has no effect on the strobes.
- R5: In a flagged cycle the state-0 `ale` pulse is left out and the state-3 pulse is kept.
- R6: With `ext_exec` high and the cycle unflagged, `psen_n` is 0 during states 0, 1, 3 and 4 and 1 during states 2 and 5. With `ext_exec` low, `psen_n` stays 1.
- R7: In a flagged cycle `psen_n` stays 1 for all twelve clocks, even with `ext_exec` high.
- R8: With `ale_off` high and `ext_exec` low, `ale` stays 0 in unflagged cycles and pulses only in flagged cycles, at the state-3 slot.
- R9: With `ext_exec` high, `ale_off` has no effect and `ale` follows R3 and R5.
- R10: With `idle_mode` high and `pdown_mode` low, `ale` and `psen_n` are both 1 and `state_idx` keeps advancing.
- R11: With `pdown_mode` high, `ale` and `psen_n` are both 0 and `state_idx` holds its value. This overrides idle. When power-down ends, the count resumes from the held state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| ale_off | input | 1 | Software ALE-disable bit |
| ext_exec | input | 1 | High while code is fetched from external program memory |
| xdata_cyc | input | 1 | Flags that the next machine cycle is an external data access or code-table read |
| idle_mode | input | 1 | Idle mode request |
| pdown_mode | input | 1 | Power-down mode request |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-store read strobe, active low |
| state_idx | output | $clog2(STATES) | Current state within the machine cycle, 0 to 5 |

## Verification
The bench targets the cycle flag at the wrong edge: `xdata_cyc` is raised at every edge except the end of state 5. A design that samples it continuously would drop pulses in cycles that should be untouched. The flagged cycle is checked both for the state-0 latch pulse and for the two read windows. A design that drops the wrong latch pulse, or only one read window, shows up as a missing or extra strobe. The ALE-disable bit is toggled with external execution on and off, so a design that ignores the override silences `ale` during external fetch. Power-down is entered in the middle of a state and then released, which exposes a timebase that keeps running or restarts at zero, and idle is checked to keep counting while the strobes sit high.

// File: rtl/msc_pkg.sv
package msc_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2
  } pmode_e;

  typedef struct packed {
    logic ale;
    logic psen_n;
  } strobe_t;

  localparam strobe_t STROBE_RESET = '{ale: 1'b0, psen_n: 1'b1};
  localparam strobe_t STROBE_IDLE  = '{ale: 1'b1, psen_n: 1'b1};
  localparam strobe_t STROBE_DOWN  = '{ale: 1'b0, psen_n: 1'b0};
endpackage

// File: rtl/msc_timebase.sv
module msc_timebase #(
  parameter int unsigned STATES       = 6,
  parameter int unsigned PH_PER_STATE = 2,
  localparam int unsigned SW = (STATES > 1) ? $clog2(STATES) : 1,
  localparam int unsigned HW = (PH_PER_STATE > 1) ? $clog2(PH_PER_STATE) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  output logic [SW-1:0] state_q,
  output logic [SW-1:0] state_d,
  output logic [HW-1:0] half_d,
  output logic          wrap
);
  localparam logic [SW-1:0] LAST_S = SW'(STATES - 1);
  localparam logic [HW-1:0] LAST_H = HW'(PH_PER_STATE - 1);

  logic [HW-1:0] half_q;

  // next-state: half-state counter rolls into state counter
  always_comb begin
    state_d = state_q;
    half_d  = half_q;
    wrap    = 1'b0;
    if (run_en) begin
      if (half_q == LAST_H) begin
        half_d = '0;
        if (state_q == LAST_S) begin
          state_d = '0;
          wrap    = 1'b1;
        end else begin
          state_d = state_q + 1'b1;
        end
      end else begin
        half_d = half_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      half_q  <= '0;
    end else if (run_en) begin
      state_q <= state_d;
      half_q  <= half_d;
    end
  end
endmodule

// File: rtl/msc_cycle_flag.sv
module msc_cycle_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic flag_in,
  output logic flag_d
);
  logic flag_q;

  // the flag for the coming machine cycle is captured only at the wrap
  always_comb begin
    flag_d = load ? flag_in : flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (load) begin
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/msc_strobe_dec.sv
module msc_strobe_dec
  import msc_pkg::*;
#(
  parameter int unsigned STATES       = 6,
  parameter int unsigned PH_PER_STATE = 2,
  parameter int unsigned ALE_S_A      = 0,
  parameter int unsigned ALE_S_B      = 3,
  parameter int unsigned RD_S_A       = 0,
  parameter int unsigned RD_S_B       = 3,
  parameter int unsigned RD_LEN       = 2,
  localparam int unsigned SW = (STATES > 1) ? $clog2(STATES) : 1,
  localparam int unsigned HW = (PH_PER_STATE > 1) ? $clog2(PH_PER_STATE) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] state_d,
  input  logic [HW-1:0] half_d,
  input  logic          flag_d,
  input  logic          ext_exec,
  input  logic          ale_off,
  input  pmode_e        pmode,
  output strobe_t       strobe_q
);
  localparam logic [HW-1:0] LATE_H = HW'(PH_PER_STATE - 1);

  logic [STATES-1:0] ale_mask;
  logic [STATES-1:0] rd_mask;

  for (genvar g = 0; g < STATES; g++) begin : g_slot
    assign ale_mask[g] = (g == ALE_S_A) || (g == ALE_S_B);
    assign rd_mask[g]  = ((g >= RD_S_A) && (g < RD_S_A + RD_LEN)) ||
                         ((g >= RD_S_B) && (g < RD_S_B + RD_LEN));
  end

  logic    ale_slot;
  logic    ale_skip;
  logic    ale_allow;
  logic    rd_on;
  strobe_t strobe_d;

  always_comb begin
    ale_slot  = ale_mask[state_d] && (half_d == LATE_H);
    ale_skip  = flag_d && (state_d == SW'(ALE_S_A));
    ale_allow = ext_exec || !ale_off || flag_d;
    rd_on     = ext_exec && rd_mask[state_d] && !flag_d;
    unique case (pmode)
      PM_DOWN: strobe_d = STROBE_DOWN;
      PM_IDLE: strobe_d = STROBE_IDLE;
      default: begin
        strobe_d.ale    = ale_slot && !ale_skip && ale_allow;
        strobe_d.psen_n = !rd_on;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= STROBE_RESET;
    end else begin
      strobe_q <= strobe_d;
    end
  end
endmodule

// File: rtl/msc_bus_strobes.sv
module msc_bus_strobes
  import msc_pkg::*;
#(
  parameter int unsigned STATES       = 6,
  parameter int unsigned PH_PER_STATE = 2,
  localparam int unsigned SW = (STATES > 1) ? $clog2(STATES) : 1,
  localparam int unsigned HW = (PH_PER_STATE > 1) ? $clog2(PH_PER_STATE) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale_off,
  input  logic          ext_exec,
  input  logic          xdata_cyc,
  input  logic          idle_mode,
  input  logic          pdown_mode,
  output logic          ale,
  output logic          psen_n,
  output logic [SW-1:0] state_idx
);
  logic          rst_meta_n;
  logic          rst_sync_n;
  pmode_e        pmode;
  logic          run_en;
  logic [SW-1:0] state_d;
  logic [HW-1:0] half_d;
  logic          wrap;
  logic          flag_d;
  strobe_t       strobe_q;

  // asynchronous assertion, synchronised release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  always_comb begin
    if (pdown_mode)     pmode = PM_DOWN;
    else if (idle_mode) pmode = PM_IDLE;
    else                pmode = PM_RUN;
    run_en = (pmode != PM_DOWN);
  end

  msc_timebase #(
    .STATES       (STATES),
    .PH_PER_STATE (PH_PER_STATE)
  ) u_timebase (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run_en  (run_en),
    .state_q (state_idx),
    .state_d (state_d),
    .half_d  (half_d),
    .wrap    (wrap)
  );

  msc_cycle_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (wrap),
    .flag_in (xdata_cyc),
    .flag_d  (flag_d)
  );

  msc_strobe_dec #(
    .STATES       (STATES),
    .PH_PER_STATE (PH_PER_STATE)
  ) u_dec (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .state_d  (state_d),
    .half_d   (half_d),
    .flag_d   (flag_d),
    .ext_exec (ext_exec),
    .ale_off  (ale_off),
    .pmode    (pmode),
    .strobe_q (strobe_q)
  );

  assign ale    = strobe_q.ale;
  assign psen_n = strobe_q.psen_n;
endmodule

// File: rtl/msc_bus_strobes_chk.sv
module msc_bus_strobes_chk #(
  parameter int unsigned STATES = 6,
  localparam int unsigned SW = (STATES > 1) ? $clog2(STATES) : 1
) (
  input logic          clk,
  input logic          rst_q,
  input logic          ext_exec,
  input logic          idle_mode,
  input logic          pdown_mode,
  input logic          ale,
  input logic          psen_n,
  input logic [SW-1:0] state_idx
);
  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_q)
    state_idx <= SW'(STATES - 1));

  // R11
  pd_low_chk: assert property (@(posedge clk) disable iff (!rst_q)
    pdown_mode |=> (!ale && !psen_n));

  // R11
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    pdown_mode |=> $stable(state_idx));

  // R10
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (idle_mode && !pdown_mode) |=> (ale && psen_n));

  // R6
  no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!ext_exec && !pdown_mode) |=> psen_n);

  // R3
  ale_width_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (ale && !$past(idle_mode) && !idle_mode && !pdown_mode) |=> !ale);
endmodule

bind msc_bus_strobes msc_bus_strobes_chk #(.STATES(STATES)) u_chk (
  .clk        (clk),
  .rst_q      (rst_sync_n),
  .ext_exec   (ext_exec),
  .idle_mode  (idle_mode),
  .pdown_mode (pdown_mode),
  .ale        (ale),
  .psen_n     (psen_n),
  .state_idx  (state_idx)
);

// File: tb/test_msc_bus_strobes.sv
module test_msc_bus_strobes;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ale_off = 1'b0, ext_exec = 1'b0, xdata_cyc = 1'b0;
  logic       idle_mode = 1'b0, pdown_mode = 1'b0;
  logic       ale, psen_n;
  logic [2:0] state_idx;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int m_s = 0, m_h = 0;
  bit m_f = 0;
  string force_tag = "";

  always #2 clk = ~clk;

  msc_bus_strobes i_msc_bus_strobes (
    .clk(clk), .rst_n(rst_n), .ale_off(ale_off), .ext_exec(ext_exec),
    .xdata_cyc(xdata_cyc), .idle_mode(idle_mode), .pdown_mode(pdown_mode),
    .ale(ale), .psen_n(psen_n), .state_idx(state_idx)
  );

  task automatic chk(string tag, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (state %0d half %0d)",
               tag, what, act, exp, m_s, m_h);
    end
  endtask

  function automatic bit exp_ale(bit f);
    if (m_h != 1) return 0;
    if (!(m_s == 0 || m_s == 3)) return 0;
    if (f && m_s == 0) return 0;
    return ext_exec || !ale_off || f;
  endfunction

  function automatic bit exp_psen_n(bit f);
    bool_rd: begin end
    return !(ext_exec && (m_s == 0 || m_s == 1 || m_s == 3 || m_s == 4) && !f);
  endfunction

  // advance the model over one rising edge, then compare at the falling edge
  task automatic step();
    bit e_ale, e_psn;
    string ta, tp, ti;
    if (!pdown_mode) begin
      if (m_h == 1) begin
        m_h = 0;
        if (m_s == 5) begin m_s = 0; m_f = xdata_cyc; end
        else m_s++;
      end else m_h = 1;
    end
    if (pdown_mode) begin
      e_ale = 0; e_psn = 0; ta = "R11"; tp = "R11"; ti = "R11";
    end else if (idle_mode) begin
      e_ale = 1; e_psn = 1; ta = "R10"; tp = "R10"; ti = "R10";
    end else begin
      e_ale = exp_ale(m_f);
      e_psn = exp_psen_n(m_f);
      ti = "R2";
      if (ale_off && !ext_exec) ta = "R8";
      else if (ale_off)         ta = "R9";
      else if (m_f)             ta = "R5";
      else                      ta = "R3";
      tp = (m_f && ext_exec) ? "R7" : "R6";
    end
    if (force_tag != "") begin ta = force_tag; tp = force_tag; end
    @(negedge clk);
    chk(ta, int'(ale), int'(e_ale), "ale");
    chk(tp, int'(psen_n), int'(e_psn), "psen_n");
    chk(ti, int'(state_idx), m_s, "state_idx");
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: held in reset
    chk("R1", int'(ale), 0, "ale"); chk("R1", int'(psen_n), 1, "psen_n");
    chk("R1", int'(state_idx), 0, "state_idx");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: synchroniser still holding reset
    chk("R1", int'(ale), 0, "ale"); chk("R1", int'(psen_n), 1, "psen_n");
    chk("R1", int'(state_idx), 0, "state_idx");

    run(36);                                   // R3, R2 internal execution
    ext_exec = 1; run(36);                     // R6
    // R4: flag high everywhere except the closing edge of state 5
    force_tag = "R4";
    for (int i = 0; i < 36; i++) begin
      xdata_cyc = !(m_s == 5 && m_h == 1);
      step();
    end
    force_tag = "";
    // R5, R7: flag sampled at the wrap only
    for (int i = 0; i < 48; i++) begin
      xdata_cyc = (m_s == 5 && m_h == 1) && (i < 24);
      step();
    end
    xdata_cyc = 0;
    ale_off = 1; run(24);                      // R9 external overrides disable
    ext_exec = 0; run(24);                     // R8 silent
    for (int i = 0; i < 36; i++) begin         // R8 flagged cycles pulse at state 3
      xdata_cyc = (m_s == 5 && m_h == 1);
      step();
    end
    xdata_cyc = 0; ale_off = 0; ext_exec = 1;
    idle_mode = 1; run(20);                    // R10
    pdown_mode = 1; run(3); idle_mode = 0; run(7); // R11 overrides idle, holds
    pdown_mode = 0; run(30);                   // R11 resume

    for (int b = 0; b < 120; b++) begin
      ext_exec   = $urandom_range(0, 1);
      ale_off    = $urandom_range(0, 1);
      idle_mode  = ($urandom_range(0, 9) == 0);
      pdown_mode = ($urandom_range(0, 9) == 0);
      for (int i = 0; i < 25; i++) begin
        xdata_cyc = $urandom_range(0, 1);
        step();
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule